// File: doc/BRIEF.md
# Byte-Loaded Double-Buffered Converter Code Register

This block is the digital front end of a 16-bit converter that is fed from an 8-bit bus. A byte bus, a byte-select input and an active-low write strobe fill the two halves of a 16-bit staging register, one half at a time. An active-low load strobe copies the staging register into the output register. The output register drives the converter code. Because the registers are double-buffered, the host can change both halves without the code passing through a mixed value.

An active-low clear wins over every other control. It forces both registers either to zero or to midscale, as chosen by a clear-level input. When write and load are low together the block runs in flow-through. One half of the staging register and the output register then follow the bus directly. The half that is transparent is the one the byte select chose in the last cycle before write went low. All controls are levels sampled on one clock. A separate active-low reset clears everything to zero.

Top module: `fbd_dac_front`

## Requirements
- R1: With clear high, write low, load high and byte select 0, the bus byte is stored into bits 7:0 of the staging register.
- R2: With clear high, write low, load high and byte select 1, the bus byte is stored into bits 15:8 of the staging register.
- R3: A write leaves the unselected half of the staging register unchanged, and leaves the code output unchanged.
- R4: With clear high, load low and write high, the whole staging register is copied into the output register, and the code output shows it on the next cycle.
- R5: With clear low and clear level 0, both the staging register and the output register become 0x0000.
- R6: With clear low and clear level 1, both the staging register and the output register become 0x8000.
- R7: Clear takes priority over write and load in any cycle where it is low.
- R8: With clear high and both write and load low, the selected half of the staging register takes the bus byte. The output register takes the updated staging value. The other half is held.
- R9: The byte select is captured on every cycle in which write is high. During flow-through, the half that is updated follows this captured value, not the live pin.
- R10: With write, load and clear all high, neither register changes.
- R11: After reset the code is 0x0000. A new code appears only after both halves have been written and a load has occurred, and either write order gives the same code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all registers to zero |
| bus_byte | input | 8 | Data byte from the host bus |
| wr_n | input | 1 | Active-low write strobe |
| hi_sel | input | 1 | Byte select: 0 selects the low half, 1 selects the high half |
| ld_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low clear |
| clr_mid | input | 1 | Clear level: 0 clears to zero, 1 clears to midscale |
| code | output | 16 | Converter code from the output register |

## Verification
The assertions assume that every control input is a settled level at each clock edge and that reset is held for at least one edge before any stimulus. The byte-select property expects each write to be preceded by at least one cycle with write high, because it compares against the select value captured in that cycle. The bench respects these assumptions. It changes inputs only on the falling edge and always drives write high before starting a flow-through run. Apart from that it combines strobes freely, including clear asserted together with write and load.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  parameter int unsigned BYTE_W = 8;
  localparam int unsigned CODE_W = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CODE_W-1:0] code_t;

  // Replace one half of a code word with a new byte.
  function automatic code_t merge_byte(input code_t cur, input byte_t b, input logic hi);
    code_t r;
    r = cur;
    if (hi) r[CODE_W-1:BYTE_W] = b;
    else    r[BYTE_W-1:0]      = b;
    return r;
  endfunction

  // Value that clear forces into both registers.
  function automatic code_t clear_code(input logic mid);
    code_t r;
    r = '0;
    r[CODE_W-1] = mid;
    return r;
  endfunction
endpackage

// File: rtl/fbd_sel_hold.sv
module fbd_sel_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  input  logic hi_sel,
  output logic sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= 1'b0;
    else if (wr_n) sel_q <= hi_sel;
  end

  // R9: captured select follows the pin whenever write was idle
  p_sel_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> (sel_q == $past(hi_sel)));
  // R9: captured select frozen while write is held low
  p_sel_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> $stable(sel_q));
endmodule

// File: rtl/fbd_in_reg.sv
module fbd_in_reg
  import fbd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_evt,
  input  code_t clr_val,
  input  logic  wr_evt,
  input  logic  sel_eff,
  input  byte_t bus_byte,
  output code_t in_q
);
  localparam int unsigned NUM_BYTES = CODE_W / BYTE_W;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_half
    logic hit;
    assign hit = wr_evt && (sel_eff == 1'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       in_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (clr_evt) in_q[b*BYTE_W +: BYTE_W] <= clr_val[b*BYTE_W +: BYTE_W];
      else if (hit)     in_q[b*BYTE_W +: BYTE_W] <= bus_byte;
    end
  end

  // R1: low half written when select is 0
  p_low_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && wr_evt && !sel_eff) |=> (in_q[BYTE_W-1:0] == $past(bus_byte)));
  // R2: high half written when select is 1
  p_high_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && wr_evt && sel_eff) |=> (in_q[CODE_W-1:BYTE_W] == $past(bus_byte)));
  // R3: other half untouched by a low-half write
  p_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && !sel_eff) |=> $stable(in_q[CODE_W-1:BYTE_W]));
  // R3: other half untouched by a high-half write
  p_hold_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && sel_eff) |=> $stable(in_q[BYTE_W-1:0]));
endmodule

// File: rtl/fbd_dac_reg.sv
module fbd_dac_reg
  import fbd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_evt,
  input  code_t clr_val,
  input  logic  ld_evt,
  input  logic  flow_evt,
  input  logic  sel_eff,
  input  byte_t bus_byte,
  input  code_t in_q,
  output code_t dac_q
);
  code_t dac_next;

  always_comb begin
    dac_next = dac_q;
    if (flow_evt)    dac_next = merge_byte(in_q, bus_byte, sel_eff);
    else if (ld_evt) dac_next = in_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dac_q <= '0;
    else if (clr_evt) dac_q <= clr_val;
    else              dac_q <= dac_next;
  end

  // R4: a plain load copies the staging register
  p_load_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && ld_evt && !flow_evt) |=> (dac_q == $past(in_q)));
  // R8: during flow-through the output register equals the new staging value
  p_flow_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && flow_evt) |=> (dac_q == in_q));
endmodule

// File: rtl/fbd_dac_front.sv
module fbd_dac_front
  import fbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] bus_byte,
  input  logic              wr_n,
  input  logic              hi_sel,
  input  logic              ld_n,
  input  logic              clr_n,
  input  logic              clr_mid,
  output logic [CODE_W-1:0] code
);
  // Named control events
  logic  clr_evt, wr_evt, ld_evt, flow_evt, sel_q, sel_eff;
  code_t clr_val, in_q, dac_q;

  assign clr_evt  = !clr_n;
  assign wr_evt   = !wr_n;
  assign ld_evt   = !ld_n;
  assign flow_evt = wr_evt && ld_evt;
  assign sel_eff  = flow_evt ? sel_q : hi_sel;
  assign clr_val  = clear_code(clr_mid);

  fbd_sel_hold u_sel (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .hi_sel(hi_sel), .sel_q(sel_q)
  );

  fbd_in_reg u_in (
    .clk(clk), .rst_n(rst_n), .clr_evt(clr_evt), .clr_val(clr_val),
    .wr_evt(wr_evt), .sel_eff(sel_eff), .bus_byte(bus_byte), .in_q(in_q)
  );

  fbd_dac_reg u_dac (
    .clk(clk), .rst_n(rst_n), .clr_evt(clr_evt), .clr_val(clr_val),
    .ld_evt(ld_evt), .flow_evt(flow_evt), .sel_eff(sel_eff),
    .bus_byte(bus_byte), .in_q(in_q), .dac_q(dac_q)
  );

  assign code = dac_q;

  // R5: clear to zero empties both registers
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !clr_mid) |=> (in_q == '0 && dac_q == '0));
  // R6 and R7: midscale clear wins over write and load
  p_clear_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && clr_mid) |=> (in_q == {1'b1, {(CODE_W-1){1'b0}}} && dac_q == in_q));
  // R10: all strobes idle keeps both registers
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && wr_n && ld_n) |=> ($stable(in_q) && $stable(code)));
  // R3: a write without load leaves the code output
  p_write_no_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !wr_n && ld_n) |=> $stable(code));
endmodule

// File: tb/sim_fbd_dac_front.sv
module sim_fbd_dac_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_byte = 8'h00;
  logic       wr_n = 1'b1, hi_sel = 1'b0, ld_n = 1'b1, clr_n = 1'b1, clr_mid = 1'b0;
  logic [15:0] code;

  int checks = 0, errors = 0;
  bit done = 0;

  // Behavioural model state
  logic [15:0] m_stage = 16'h0, m_out = 16'h0;
  logic        m_sel = 1'b0;

  always #5 clk = ~clk;

  fbd_dac_front u0 (
    .clk(clk), .rst_n(rst_n), .bus_byte(bus_byte), .wr_n(wr_n), .hi_sel(hi_sel),
    .ld_n(ld_n), .clr_n(clr_n), .clr_mid(clr_mid), .code(code)
  );

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (code !== exp) begin
      errors++;
      $display("FAIL %s: code=%h expected=%h", req, code, exp);
    end
  endtask

  // One clock with the given controls; model updated, output compared.
  task automatic step(input logic [7:0] d, input logic w, input logic s, input logic l,
                      input logic c, input logic m, input string req);
    logic hi;
    @(negedge clk);
    bus_byte = d; wr_n = w; hi_sel = s; ld_n = l; clr_n = c; clr_mid = m;
    @(posedge clk);
    #1;
    if (!c) begin
      m_stage = m ? 16'h8000 : 16'h0000;
      m_out   = m_stage;
    end else if (!w && !l) begin
      hi = m_sel;
      if (hi) m_stage = {d, m_stage[7:0]}; else m_stage = {m_stage[15:8], d};
      m_out = m_stage;
    end else if (!w) begin
      if (s) m_stage = {d, m_stage[7:0]}; else m_stage = {m_stage[15:8], d};
    end else if (!l) begin
      m_out = m_stage;
    end
    if (w) m_sel = s;
    #1;
    check(req, m_out);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: code=%h expected=finish", code);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R11 reset", 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    // R1, R2, R11: low then high, then load
    step(8'h34, 0, 0, 1, 1, 0, "R1 low write, no output");
    step(8'h12, 0, 1, 1, 1, 0, "R2 high write, no output");
    step(8'h00, 1, 0, 1, 1, 0, "R10 idle");
    step(8'hFF, 1, 0, 0, 1, 0, "R4 load 1234");
    check("R11 low-then-high", 16'h1234);

    // R3, R11: high then low gives the same as writing in the other order
    step(8'hAB, 0, 1, 1, 1, 0, "R3 high write holds code");
    step(8'hCD, 0, 0, 1, 1, 0, "R3 low write holds code");
    step(8'h00, 1, 1, 0, 1, 0, "R4 load ABCD");
    check("R11 high-then-low", 16'hABCD);
    step(8'h77, 0, 0, 1, 1, 0, "R3 low rewrite");
    step(8'h00, 1, 0, 0, 1, 0, "R3 high byte kept");
    check("R3 ab77", 16'hAB77);

    // R10: idle with bus changing
    for (int i = 0; i < 4; i++) step(8'(i * 37), 1, i[0], 1, 1, 0, "R10 idle hold");

    // R5: clear to zero, then load shows staging register also zero
    step(8'h55, 1, 0, 1, 0, 0, "R5 clear zero");
    step(8'h00, 1, 0, 0, 1, 0, "R5 staging zero");
    // R6: clear to midscale
    step(8'h12, 0, 1, 1, 1, 0, "R6 prep write");
    step(8'h00, 1, 0, 1, 0, 1, "R6 clear mid");
    step(8'h00, 1, 0, 0, 1, 0, "R6 staging mid");
    check("R6 midscale", 16'h8000);
    // R7: clear beats write plus load
    step(8'hEE, 0, 1, 0, 0, 0, "R7 clear over flow");
    step(8'hEE, 0, 0, 1, 0, 1, "R7 clear over write");
    step(8'hEE, 1, 0, 0, 0, 0, "R7 clear over load");

    // R8, R9: capture select 1, then flow with live pin 0 -> high half moves
    step(8'h00, 1, 1, 1, 1, 0, "R9 capture select 1");
    step(8'h5A, 0, 0, 0, 1, 0, "R9 flow uses captured high");
    step(8'h66, 0, 0, 0, 1, 0, "R8 flow tracks");
    check("R8 high transparent", 16'h6600);
    step(8'h00, 1, 0, 1, 1, 0, "R9 capture select 0");
    step(8'h3C, 0, 1, 0, 1, 0, "R9 flow uses captured low");
    step(8'hC3, 0, 1, 0, 1, 0, "R8 flow tracks low");
    check("R8 low transparent", 16'h66C3);
    step(8'h00, 1, 1, 1, 1, 0, "R10 idle after flow");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule